// File: doc/BRIEF.md
# Dual-Plane Nonvolatile Memory Write Controller

This block models a byte-wide nonvolatile store behind a multiplexed 8-bit address/data bus. A host puts the low address byte on `ad_in` with `addr_stb` high. The upper address bits travel on `addr_hi`. A later cycle with `data_stb` high performs the access, and `rd_nwr` selects read or write. The store is split into two independent planes by the top address bit. A programming cycle in one plane never stalls reads from the other, so code can keep running from one plane while the other is rewritten.

Writes pass through three gates. The first is a three-write unlock sequence. The second is a lock register with one bit per eighth of the array. The third is the `wr_allow` pin. Accepted bytes collect in a 32-byte page buffer. The page closes on a write outside the page or after an idle timeout, and all its bytes are then committed together. While the commit runs, reads of the busy plane return a status byte whose bit 6 flips on every such read.

The command sequencer (`nvm_cmd_seq`) has the states SQ_IDLE, SQ_KEY1, SQ_KEY2, SQ_ARMED, SQ_PAGE and SQ_LOCKLD:
- SQ_IDLE goes to SQ_KEY1 on AAh written to the first key address.
- SQ_KEY1 goes to SQ_KEY2 on 55h written to the second key address.
- SQ_KEY2 goes to SQ_ARMED on A0h, or to SQ_LOCKLD on C0h, written to the first key address.
- SQ_ARMED goes to SQ_PAGE on the first data write.
- SQ_PAGE goes back to SQ_IDLE on an out-of-page write or on a timeout.
- SQ_LOCKLD goes back to SQ_IDLE on the next write.
- Any other write in SQ_KEY1 or SQ_KEY2 returns the sequencer to SQ_IDLE.

The commit engine (`nvm_commit`) has the states CM_IDLE, CM_PROG and CM_SETTLE:
- CM_IDLE goes to CM_PROG when a page closes holding at least one byte.
- CM_PROG goes to CM_SETTLE after sweeping all 32 slots.
- CM_SETTLE goes back to CM_IDLE when the cycle counter reaches `WR_CYCLES-1`.

Top module: `nvm_dualplane_ctrl`

## Requirements
- R1: After reset, `ad_out` reads 00h, the lock register is all clear and the sequencer is in SQ_IDLE.
- R2: A cycle with `chip_en` and `addr_stb` captures `ad_in` as address bits 7:0. The full address is {`addr_hi`, captured byte}. A read (`chip_en`, `data_stb`, `rd_nwr`=1) drives the addressed byte on `ad_out` from the next cycle, and the value holds until the next accepted read.
- R3: Address bit AW-1 selects the plane. While a commit runs in one plane, a read of the other plane returns its array data with the normal one-cycle latency.
- R4: A data write is accepted only after AAh is written to address 1555h, 55h to 0AAAh, then A0h to 1555h. Key addresses compare on the low AW bits. Without this sequence a data write changes nothing.
- R5: A write that does not match the expected key byte and address returns the sequencer to idle. A later correct sequence still works.
- R6: The sequence AAh@1555h, 55h@0AAAh, C0h@1555h followed by one write loads the lock register with that write's data. Bit i locks the block whose address bits [AW-1:AW-3] equal i. The value holds until the register is reloaded or reset.
- R7: A byte aimed at a locked block is discarded. With `wr_allow` low, data bytes and lock-register loads are discarded.
- R8: Bytes that share address bits above bit 4 form one page and are committed together. A repeated write to one slot keeps the last value.
- R9: A page closes on a write to a different page, and that write is discarded. A page also closes after `PAGE_TMO` cycles without a write. A shorter gap keeps the page open.
- R10: A commit lasts `WR_CYCLES` cycles. All writes during a commit are ignored.
- R11: During a commit, a read of the busy plane returns 00h or 40h. The first such read returns 00h, and bit 6 inverts on each further read. After the commit, the plane returns the new data.
- R12: With `chip_en` low, strobes have no effect: `ad_out` and the array do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chip_en | input | 1 | Enables all strobes |
| addr_stb | input | 1 | Captures low address byte from `ad_in` |
| data_stb | input | 1 | Performs the access |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| wr_allow | input | 1 | Write-control pin, low inhibits writes |
| addr_hi | input | AW-8 | Upper address bits |
| ad_in | input | 8 | Shared bus, address or data in |
| ad_out | output | 8 | Read data or status byte |

## Verification
The properties assume that the host never raises `addr_stb` and `data_stb` in the same cycle. They also assume that the address captured before a `data_stb` belongs to that access. The bench's bus tasks hold each strobe for exactly one cycle and always latch the address in the cycle before the data phase. The status properties assume that `busy` and the plane number are stable across a read. The bench therefore times its busy-plane reads well inside the commit window it computes from `PAGE_TMO` and `WR_CYCLES`.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_ARMED,
        SQ_PAGE,
        SQ_LOCKLD
    } seq_state_t;

    typedef enum logic [1:0] {
        CM_IDLE,
        CM_PROG,
        CM_SETTLE
    } cm_state_t;

    localparam logic [7:0]  KEY_BYTE1 = 8'hAA;
    localparam logic [7:0]  KEY_BYTE2 = 8'h55;
    localparam logic [7:0]  OP_PAGE   = 8'hA0;
    localparam logic [7:0]  OP_LOCK   = 8'hC0;
    localparam logic [15:0] KEY_ADDR1 = 16'h1555;
    localparam logic [15:0] KEY_ADDR2 = 16'h0AAA;
endpackage

// File: rtl/nvm_plane.sv
module nvm_plane #(
    parameter int PAW = 12
) (
    input  logic           clk,
    input  logic           we,
    input  logic [PAW-1:0] waddr,
    input  logic [7:0]     wdata,
    input  logic           re,
    input  logic [PAW-1:0] raddr,
    output logic [7:0]     rdata
);
    localparam int DEPTH = 1 << PAW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
    import nvm_pkg::*;
#(
    parameter int AW       = 13,
    parameter int PAGE_AW  = 5,
    parameter int PAGE_TMO = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_go,
    input  logic [AW-1:0]         wr_addr,
    input  logic [7:0]            wr_data,
    input  logic                  wr_allow,
    input  logic                  busy,
    output logic                  ld_en,
    output logic [PAGE_AW-1:0]    ld_slot,
    output logic [7:0]            ld_data,
    output logic                  close,
    output logic [AW-PAGE_AW-1:0] close_page
);
    localparam int PGW = AW - PAGE_AW;
    localparam int TW  = $clog2(PAGE_TMO + 1);
    localparam logic [AW-1:0] CMD1 = KEY_ADDR1[AW-1:0];
    localparam logic [AW-1:0] CMD2 = KEY_ADDR2[AW-1:0];
    localparam logic [TW-1:0] TMO_LAST = TW'(PAGE_TMO - 1);

    seq_state_t     state, state_n;
    logic [PGW-1:0] page_q;
    logic [TW-1:0]  tmo_q;
    logic [7:0]     prot_q;

    logic       acc, same_page, allowed, hit1, hit2;
    logic [2:0] blk;

    always_comb begin
        acc       = wr_go && !busy;
        same_page = (wr_addr[AW-1:PAGE_AW] == page_q);
        blk       = wr_addr[AW-1:AW-3];
        allowed   = wr_allow && !prot_q[blk];
        hit1      = (wr_addr == CMD1);
        hit2      = (wr_addr == CMD2);
    end

    always_comb begin
        state_n = state;
        unique case (state)
            SQ_IDLE: begin
                if (acc) state_n = (hit1 && wr_data == KEY_BYTE1) ? SQ_KEY1 : SQ_IDLE;
            end
            SQ_KEY1: begin
                if (acc) state_n = (hit2 && wr_data == KEY_BYTE2) ? SQ_KEY2 : SQ_IDLE;
            end
            SQ_KEY2: begin
                if (acc) begin
                    if (hit1 && wr_data == OP_PAGE)      state_n = SQ_ARMED;
                    else if (hit1 && wr_data == OP_LOCK) state_n = SQ_LOCKLD;
                    else                                 state_n = SQ_IDLE;
                end
            end
            SQ_ARMED: begin
                if (acc) state_n = SQ_PAGE;
            end
            SQ_PAGE: begin
                if (acc && !same_page)             state_n = SQ_IDLE;
                else if (!acc && tmo_q == TMO_LAST) state_n = SQ_IDLE;
            end
            SQ_LOCKLD: begin
                if (acc) state_n = SQ_IDLE;
            end
            default: state_n = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        ld_en      = acc && allowed &&
                     (state == SQ_ARMED || (state == SQ_PAGE && same_page));
        ld_slot    = wr_addr[PAGE_AW-1:0];
        ld_data    = wr_data;
        close      = (state == SQ_PAGE) && (acc ? !same_page : (tmo_q == TMO_LAST));
        close_page = page_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            tmo_q  <= '0;
            prot_q <= '0;
        end else begin
            if (state == SQ_ARMED && acc) page_q <= wr_addr[AW-1:PAGE_AW];
            if (state == SQ_PAGE && !acc) tmo_q <= tmo_q + 1'b1;
            else                          tmo_q <= '0;
            if (state == SQ_LOCKLD && acc && wr_allow) prot_q <= wr_data;
        end
    end

    p_prot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == SQ_LOCKLD && acc) |=> $stable(prot_q));

    p_ld_allowed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |-> (wr_allow && !prot_q[wr_addr[AW-1:AW-3]]));
endmodule

// File: rtl/nvm_commit.sv
module nvm_commit
    import nvm_pkg::*;
#(
    parameter int AW        = 13,
    parameter int PAGE_AW   = 5,
    parameter int WR_CYCLES = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_en,
    input  logic [PAGE_AW-1:0]    ld_slot,
    input  logic [7:0]            ld_data,
    input  logic                  close,
    input  logic [AW-PAGE_AW-1:0] close_page,
    output logic                  busy,
    output logic                  busy_plane,
    output logic                  mw_en,
    output logic [AW-2:0]         mw_addr,
    output logic [7:0]            mw_data
);
    localparam int NB  = 1 << PAGE_AW;
    localparam int PGW = AW - PAGE_AW;
    localparam int CW  = $clog2(WR_CYCLES);
    localparam logic [CW-1:0] SLOT_LAST = CW'(NB - 1);
    localparam logic [CW-1:0] CYC_LAST  = CW'(WR_CYCLES - 1);

    cm_state_t        state, state_n;
    logic [7:0]       pbuf [NB];
    logic [NB-1:0]    pval;
    logic [PGW-1:0]   page_q;
    logic [CW-1:0]    cnt_q;
    logic [PAGE_AW-1:0] slot;
    logic             finish;

    always_comb begin
        state_n = state;
        unique case (state)
            CM_IDLE:   if (close && |pval)      state_n = CM_PROG;
            CM_PROG:   if (cnt_q == SLOT_LAST)  state_n = CM_SETTLE;
            CM_SETTLE: if (cnt_q == CYC_LAST)   state_n = CM_IDLE;
            default:   state_n = CM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CM_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        finish     = (state == CM_SETTLE) && (cnt_q == CYC_LAST);
        slot       = cnt_q[PAGE_AW-1:0];
        busy       = (state != CM_IDLE);
        busy_plane = page_q[PGW-1];
        mw_en      = (state == CM_PROG) && pval[slot];
        mw_addr    = {page_q[PGW-2:0], slot};
        mw_data    = pbuf[slot];
    end

    always_ff @(posedge clk) begin
        if (ld_en) pbuf[ld_slot] <= ld_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pval   <= '0;
            page_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (finish)     pval <= '0;
            else if (ld_en) pval[ld_slot] <= 1'b1;
            if (state == CM_IDLE && close) page_q <= close_page;
            if (state == CM_IDLE) cnt_q <= '0;
            else                  cnt_q <= cnt_q + 1'b1;
        end
    end

    p_close_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        close |-> (state == CM_IDLE));

    p_load_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |-> (state == CM_IDLE));
endmodule

// File: rtl/nvm_dualplane_ctrl.sv
module nvm_dualplane_ctrl #(
    parameter int AW        = 13,
    parameter int PAGE_AW   = 5,
    parameter int PAGE_TMO  = 64,
    parameter int WR_CYCLES = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chip_en,
    input  logic          addr_stb,
    input  logic          data_stb,
    input  logic          rd_nwr,
    input  logic          wr_allow,
    input  logic [AW-9:0] addr_hi,
    input  logic [7:0]    ad_in,
    output logic [7:0]    ad_out
);
    localparam int PAW = AW - 1;
    localparam int PGW = AW - PAGE_AW;

    logic [7:0]    lo_q;
    logic [AW-1:0] full_addr;
    logic          wr_go, rd_go, rd_plane, stat_hit;

    logic               ld_en, close, busy, busy_plane, mw_en;
    logic [PAGE_AW-1:0] ld_slot;
    logic [7:0]         ld_data, mw_data;
    logic [PGW-1:0]     close_page;
    logic [PAW-1:0]     mw_addr;
    logic [7:0]         prd [2];

    logic       stat_q, sel_q, tog_q;
    logic [7:0] sval_q;

    always_comb begin
        full_addr = {addr_hi, lo_q};
        wr_go     = chip_en && data_stb && !rd_nwr;
        rd_go     = chip_en && data_stb && rd_nwr;
        rd_plane  = full_addr[AW-1];
        stat_hit  = rd_go && busy && (rd_plane == busy_plane);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   lo_q <= '0;
        else if (chip_en && addr_stb) lo_q <= ad_in;
    end

    nvm_cmd_seq #(.AW(AW), .PAGE_AW(PAGE_AW), .PAGE_TMO(PAGE_TMO)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wr_addr(full_addr),
        .wr_data(ad_in), .wr_allow(wr_allow), .busy(busy),
        .ld_en(ld_en), .ld_slot(ld_slot), .ld_data(ld_data),
        .close(close), .close_page(close_page)
    );

    nvm_commit #(.AW(AW), .PAGE_AW(PAGE_AW), .WR_CYCLES(WR_CYCLES)) u_commit (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_slot(ld_slot),
        .ld_data(ld_data), .close(close), .close_page(close_page),
        .busy(busy), .busy_plane(busy_plane), .mw_en(mw_en),
        .mw_addr(mw_addr), .mw_data(mw_data)
    );

    for (genvar p = 0; p < 2; p++) begin : g_plane
        nvm_plane #(.PAW(PAW)) u_plane (
            .clk(clk),
            .we(mw_en && (busy_plane == 1'(p))),
            .waddr(mw_addr),
            .wdata(mw_data),
            .re(rd_go && !stat_hit && (rd_plane == 1'(p))),
            .raddr(full_addr[PAW-1:0]),
            .rdata(prd[p])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= 1'b1;
            sel_q  <= 1'b0;
            sval_q <= '0;
            tog_q  <= 1'b0;
        end else begin
            if (rd_go) begin
                stat_q <= stat_hit;
                sel_q  <= rd_plane;
                if (stat_hit) sval_q <= {1'b0, tog_q, 6'b0};
            end
            if (!busy)         tog_q <= 1'b0;
            else if (stat_hit) tog_q <= ~tog_q;
        end
    end

    assign ad_out = stat_q ? sval_q : prd[sel_q];

    p_other_plane_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && busy && rd_plane != busy_plane) |=> !stat_q);

    p_status_shape_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_hit |=> (ad_out[7] == 1'b0 && ad_out[5:0] == 6'b0));

    p_toggle_flip_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_hit |=> (!busy || ad_out[6] != tog_q));
endmodule

// File: tb/nvm_dualplane_ctrl_test.sv
module nvm_dualplane_ctrl_test;
    localparam int AW   = 10;
    localparam int PAW  = 5;
    localparam int TMO  = 16;
    localparam int WRC  = 48;
    localparam int SIZE = 1 << AW;
    localparam logic [9:0] K1 = 10'h155;
    localparam logic [9:0] K2 = 10'h2AA;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_en = 1'b0, addr_stb = 1'b0, data_stb = 1'b0, rd_nwr = 1'b0;
    logic       wr_allow = 1'b1;
    logic [1:0] addr_hi = '0;
    logic [7:0] ad_in = '0;
    logic [7:0] ad_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] em [SIZE];
    logic [7:0] rv;

    always #10 clk = ~clk;

    nvm_dualplane_ctrl #(.AW(AW), .PAGE_AW(PAW), .PAGE_TMO(TMO), .WR_CYCLES(WRC)) uut (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .addr_stb(addr_stb),
        .data_stb(data_stb), .rd_nwr(rd_nwr), .wr_allow(wr_allow),
        .addr_hi(addr_hi), .ad_in(ad_in), .ad_out(ad_out)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) ^ (a >> 5));
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [9:0] a, input logic [7:0] d, input logic ce = 1'b1);
        chip_en = ce; addr_stb = 1'b1; addr_hi = a[9:8]; ad_in = a[7:0];
        @(negedge clk);
        addr_stb = 1'b0; data_stb = 1'b1; rd_nwr = 1'b0; ad_in = d;
        @(negedge clk);
        data_stb = 1'b0; chip_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [9:0] a, output logic [7:0] d, input logic ce = 1'b1);
        chip_en = ce; addr_stb = 1'b1; addr_hi = a[9:8]; ad_in = a[7:0];
        @(negedge clk);
        addr_stb = 1'b0; data_stb = 1'b1; rd_nwr = 1'b1;
        @(negedge clk);
        data_stb = 1'b0; rd_nwr = 1'b0; chip_en = 1'b0;
        d = ad_out;
    endtask

    task automatic unlock(input logic [7:0] op = 8'hA0, input logic ce = 1'b1);
        bus_wr(K1, 8'hAA, ce);
        bus_wr(K2, 8'h55, ce);
        bus_wr(K1, op, ce);
    endtask

    task automatic settle();
        cyc(TMO + 4);
        cyc(WRC + 4);
    endtask

    task automatic expect_at(input string req, input logic [9:0] a);
        logic [7:0] d;
        bus_rd(a, d);
        chk(req, d, em[a]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R10 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        chk("R1 reset ad_out", ad_out, 8'h00);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 after release", ad_out, 8'h00);

        // Sweep: fill every page; needs the clear lock register of R1
        for (int pg = 0; pg < SIZE / 32; pg++) begin
            unlock();
            for (int s = 0; s < 32; s++) begin
                bus_wr(10'(pg * 32 + s), pat(pg * 32 + s));
                em[pg * 32 + s] = pat(pg * 32 + s);
            end
            settle();
        end
        for (int a = 0; a < SIZE; a++) expect_at("R1 R2 R8 sweep", 10'(a));

        // R2: output holds after a read
        bus_rd(10'h033, rv);
        cyc(5);
        chk("R2 hold", ad_out, em[10'h033]);

        // R4: write without unlock
        bus_wr(10'h011, ~em[10'h011]);
        settle();
        expect_at("R4 no unlock", 10'h011);

        // R5: wrong byte, then wrong address
        bus_wr(K1, 8'hAA); bus_wr(K2, 8'h56); bus_wr(K1, 8'hA0);
        bus_wr(10'h012, ~em[10'h012]);
        bus_wr(K1, 8'hAA); bus_wr(K1, 8'h55); bus_wr(K1, 8'hA0);
        bus_wr(10'h013, ~em[10'h013]);
        settle();
        expect_at("R5 wrong byte", 10'h012);
        expect_at("R5 wrong addr", 10'h013);
        unlock();
        bus_wr(10'h014, 8'h3C); em[10'h014] = 8'h3C;
        settle();
        expect_at("R5 recover", 10'h014);

        // R6/R7: lock blocks 0 and 2
        unlock(8'hC0); bus_wr(10'h000, 8'h05);
        unlock(); bus_wr(10'h005, ~em[10'h005]); settle();
        expect_at("R7 locked blk0", 10'h005);
        unlock(); bus_wr(10'h085, 8'h9A); em[10'h085] = 8'h9A; settle();
        expect_at("R6 open blk1", 10'h085);
        unlock(); bus_wr(10'h105, ~em[10'h105]); settle();
        expect_at("R6 hold blk2", 10'h105);
        unlock(8'hC0); bus_wr(10'h000, 8'h00);
        unlock(); bus_wr(10'h005, 8'h77); em[10'h005] = 8'h77; settle();
        expect_at("R6 reload", 10'h005);

        // R7: write-control pin low
        wr_allow = 1'b0;
        unlock(); bus_wr(10'h020, ~em[10'h020]); settle();
        unlock(8'hC0); bus_wr(10'h000, 8'hFF);
        wr_allow = 1'b1;
        expect_at("R7 pin low data", 10'h020);
        unlock(); bus_wr(10'h021, 8'h5E); em[10'h021] = 8'h5E; settle();
        expect_at("R7 pin low lock", 10'h021);

        // R8: same slot twice
        unlock();
        bus_wr(10'h0C5, 8'h01); bus_wr(10'h0C6, 8'h02); bus_wr(10'h0C5, 8'h03);
        em[10'h0C5] = 8'h03; em[10'h0C6] = 8'h02;
        settle();
        expect_at("R8 last wins", 10'h0C5);
        expect_at("R8 neighbour", 10'h0C6);

        // R9: out-of-page write closes, short gap keeps page, long gap closes
        unlock();
        bus_wr(10'h040, 8'hE1); em[10'h040] = 8'hE1;
        bus_wr(10'h060, ~em[10'h060]);
        settle();
        expect_at("R9 closed page", 10'h040);
        expect_at("R9 outside dropped", 10'h060);
        unlock();
        bus_wr(10'h0E0, 8'h4A); cyc(TMO - 6); bus_wr(10'h0E1, 8'h4B);
        em[10'h0E0] = 8'h4A; em[10'h0E1] = 8'h4B;
        settle();
        expect_at("R9 short gap a", 10'h0E0);
        expect_at("R9 short gap b", 10'h0E1);
        unlock();
        bus_wr(10'h0F0, 8'h6D); em[10'h0F0] = 8'h6D;
        cyc(TMO + 4);
        bus_wr(10'h0F1, ~em[10'h0F1]);
        settle();
        expect_at("R9 long gap a", 10'h0F0);
        expect_at("R9 long gap b", 10'h0F1);

        // R3/R10/R11: commit in plane 1, work in plane 0
        unlock();
        for (int i = 0; i < 4; i++) begin
            bus_wr(10'(10'h200 + i), 8'(8'hB0 + i));
            em[10'h200 + i] = 8'(8'hB0 + i);
        end
        cyc(TMO + 3);
        bus_rd(10'h201, rv); chk("R11 first status", rv, 8'h00);
        expect_at("R3 other plane", 10'h010);
        bus_rd(10'h201, rv); chk("R11 toggled", rv, 8'h40);
        bus_rd(10'h230, rv); chk("R11 toggled back", rv, 8'h00);
        unlock(); bus_wr(10'h011, ~em[10'h011]);
        bus_rd(10'h200, rv); chk("R11 still busy", rv, 8'h40);
        cyc(WRC + 4);
        for (int i = 0; i < 4; i++) expect_at("R11 data after", 10'(10'h200 + i));
        settle();
        expect_at("R10 write in busy ignored", 10'h011);

        // R12: chip enable low
        bus_rd(10'h010, rv);
        bus_rd(10'h300, rv, 1'b0);
        chk("R12 read ignored", ad_out, em[10'h010]);
        unlock(8'hA0, 1'b0); bus_wr(10'h016, ~em[10'h016], 1'b0);
        settle();
        expect_at("R12 write ignored", 10'h016);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule